// File: doc/BRIEF.md
# Seven-Pin Shared-Function I/O Port

This block is a seven-pin general-purpose I/O port. Six of its pins can be handed over to serial peripheral engines. It holds an output latch and a direction register. It synchronizes the pad inputs and decides, for every pin, whether the pad is driven and from which source. A static configuration input picks one of two variants. In the bidirectional variant, direction bits turn pins into outputs. In the input-only variant, the direction register has no effect on the pads and reads back as zero.

The serial engines sit outside the block. Each is represented by one enable, plus a value and an output enable for every pin it may own. While the asynchronous serial engine is enabled it owns pins 0 (receive) and 1 (transmit). While the synchronous serial engine is enabled it owns pins 2 (master-in), 3 (master-out), 4 (clock) and 5 (slave select). Pin 6 is only ever a plain GPIO pin. On an owned pin, the engine's value and enable replace the latch and the direction bit. Software reads of the data register return the synchronized pad level, except on GPIO pins configured as outputs, where they return the latch.

Top module: `shared_port`

## Requirements
- R1: While `rstN` is low, every bit of `padOe` is 0. After reset the direction register reads 0, so all seven pins are inputs.
- R2: With `inputOnly`=0, a `wrDir` pulse stores `wrVal` into the direction register. From the next clock edge, each non-owned pin whose direction bit is 1 has `padOe`=1 and `padOut` equal to its latch bit, and `rdDir` returns the stored value.
- R3: With `inputOnly`=1, no non-owned pin ever has `padOe`=1, whatever is written with `wrDir`, and `rdDir` reads 0.
- R4: A `wrData` pulse stores `wrVal` into the output latch. Reset leaves the latch unchanged.
- R5: On a non-owned pin with direction bit 1 in the bidirectional variant, `rdData` returns the latch bit.
- R6: On any other non-owned pin, `rdData` returns the `padIn` level two clock edges earlier.
- R7: While `sciEn`=1, pins 0 and 1 take `padOut`/`padOe` from `periOut`/`periOe` bits 0 and 1, overriding the latch and the direction register.
- R8: While `spiEn`=1, pins 2 to 5 take `padOut`/`padOe` from `periOut`/`periOe` bits 2 to 5, overriding the latch and the direction register.
- R9: On a pin owned by an engine, `rdData` returns the synchronized pad level, even when its direction bit is 1.
- R10: Pin 6 is never owned by an engine. Peripheral override applies in both variants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inputOnly | input | 1 | Static variant select: 1 = input-only, 0 = bidirectional |
| wrData | input | 1 | Write strobe for the output latch |
| wrDir | input | 1 | Write strobe for the direction register |
| wrVal | input | 7 | Write value for both registers |
| rdData | output | 7 | Data register read value |
| rdDir | output | 7 | Direction register read value |
| sciEn | input | 1 | Asynchronous serial engine owns pins 0-1 |
| spiEn | input | 1 | Synchronous serial engine owns pins 2-5 |
| periOut | input | 6 | Engine pin values, bit i for pin i |
| periOe | input | 6 | Engine pin output enables, bit i for pin i |
| padIn | input | 7 | Pad input levels |
| padOut | output | 7 | Pad output values |
| padOe | output | 7 | Pad output enables |

## Verification
The assertions check four things on every cycle: the quiet pads during reset, the direction write and its read-back, the absence of GPIO drive in the input-only variant, and the two-edge path from pad to read value on pins that are not GPIO outputs. They also check that each engine's value and enable reach the pads of its pins. Only the bench scenarios can show two things. The first is that the latch survives a reset pulse. The second is the full pin-by-pin result over every direction pattern, in both variants and under all four combinations of the engine enables, including pin 6, which no engine can claim.

// File: rtl/pshare_pkg.sv
package pshare_pkg;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic latchWr;
    logic dirWr;
    logic dirLive;
  } portStrobe_t;
endpackage

// File: rtl/port_ctrl.sv
module port_ctrl
  import pshare_pkg::*;
#(
  parameter int PINS     = 7,
  parameter int SCI_BASE = 0,
  parameter int SCI_PINS = 2,
  parameter int SPI_BASE = 2,
  parameter int SPI_PINS = 4
) (
  input  logic              wrData,
  input  logic              wrDir,
  input  logic              inputOnly,
  input  logic              sciEn,
  input  logic              spiEn,
  output portStrobe_t       strobe,
  output logic [PINS-1:0]   ownMask
);
  always_comb begin
    strobe.latchWr = wrData;
    strobe.dirWr   = wrDir;
    strobe.dirLive = !inputOnly;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_own
    localparam bit IN_SCI = (i >= SCI_BASE) && (i < SCI_BASE + SCI_PINS);
    localparam bit IN_SPI = (i >= SPI_BASE) && (i < SPI_BASE + SPI_PINS);
    if (IN_SCI) begin : g_sci
      assign ownMask[i] = sciEn;
    end else if (IN_SPI) begin : g_spi
      assign ownMask[i] = spiEn;
    end else begin : g_gpio
      assign ownMask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/port_datapath.sv
module port_datapath
  import pshare_pkg::*;
#(
  parameter int PINS      = 7,
  parameter int PERI_PINS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobe_t          strobe,
  input  logic [PINS-1:0]      ownMask,
  input  logic [PINS-1:0]      wrVal,
  input  logic [PINS-1:0]      padIn,
  input  logic [PERI_PINS-1:0] periOut,
  input  logic [PERI_PINS-1:0] periOe,
  output logic [PINS-1:0]      padOut,
  output logic [PINS-1:0]      padOe,
  output logic [PINS-1:0]      rdData,
  output logic [PINS-1:0]      rdDir
);
  logic [PINS-1:0] dataLatch;
  logic [PINS-1:0] dirReg;
  logic [PINS-1:0] syncPipe [SYNC_DEPTH];
  logic [PINS-1:0] gpioOut;

  // Output latch: no reset, its power-up value is undefined.
  always_ff @(posedge clk) begin
    if (strobe.latchWr) dataLatch <= wrVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dirReg <= '0;
    else if (strobe.dirWr) dirReg <= wrVal;
  end

  // Pad synchronizer: pure pipeline, no reset needed.
  always_ff @(posedge clk) begin
    syncPipe[0] <= padIn;
    for (int s = 1; s < SYNC_DEPTH; s++) syncPipe[s] <= syncPipe[s-1];
  end

  assign gpioOut = strobe.dirLive ? dirReg : '0;
  assign rdDir   = gpioOut;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic engOut;
    logic engOe;
    if (i < PERI_PINS) begin : g_eng
      assign engOut = periOut[i];
      assign engOe  = periOe[i];
    end else begin : g_none
      assign engOut = 1'b0;
      assign engOe  = 1'b0;
    end
    always_comb begin
      if (ownMask[i]) begin
        padOut[i] = engOut;
        padOe[i]  = rstN & engOe;
        rdData[i] = syncPipe[SYNC_DEPTH-1][i];
      end else begin
        padOut[i] = dataLatch[i];
        padOe[i]  = rstN & gpioOut[i];
        rdData[i] = gpioOut[i] ? dataLatch[i] : syncPipe[SYNC_DEPTH-1][i];
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |-> padOe == '0);

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dirWr && strobe.dirLive) |=> rdDir == $past(wrVal));

  p_no_gpio_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dirLive |-> (padOe & ~ownMask) == '0);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchWr |=> $stable(dataLatch));

  p_input_path_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((rdData ^ $past(padIn, 2)) & ~(gpioOut & ~ownMask)) == '0);
endmodule

// File: rtl/shared_port.sv
module shared_port
  import pshare_pkg::*;
#(
  parameter int PINS     = 7,
  parameter int SCI_BASE = 0,
  parameter int SCI_PINS = 2,
  parameter int SPI_BASE = 2,
  parameter int SPI_PINS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inputOnly,
  input  logic            wrData,
  input  logic            wrDir,
  input  logic [PINS-1:0] wrVal,
  output logic [PINS-1:0] rdData,
  output logic [PINS-1:0] rdDir,
  input  logic            sciEn,
  input  logic            spiEn,
  input  logic [5:0]      periOut,
  input  logic [5:0]      periOe,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe
);
  localparam int PERI_PINS = 6;

  portStrobe_t     strobe;
  logic [PINS-1:0] ownMask;

  port_ctrl #(
    .PINS(PINS), .SCI_BASE(SCI_BASE), .SCI_PINS(SCI_PINS),
    .SPI_BASE(SPI_BASE), .SPI_PINS(SPI_PINS)
  ) u_ctrl (
    .wrData(wrData), .wrDir(wrDir), .inputOnly(inputOnly),
    .sciEn(sciEn), .spiEn(spiEn), .strobe(strobe), .ownMask(ownMask)
  );

  port_datapath #(.PINS(PINS), .PERI_PINS(PERI_PINS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ownMask(ownMask),
    .wrVal(wrVal), .padIn(padIn), .periOut(periOut), .periOe(periOe),
    .padOut(padOut), .padOe(padOe), .rdData(rdData), .rdDir(rdDir)
  );

  p_sci_priority_r7: assert property (@(posedge clk) disable iff (!rstN)
    sciEn |-> (padOe[SCI_BASE +: SCI_PINS] == periOe[SCI_BASE +: SCI_PINS]) &&
              (padOut[SCI_BASE +: SCI_PINS] == periOut[SCI_BASE +: SCI_PINS]));

  p_spi_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
    spiEn |-> (padOe[SPI_BASE +: SPI_PINS] == periOe[SPI_BASE +: SPI_PINS]) &&
              (padOut[SPI_BASE +: SPI_PINS] == periOut[SPI_BASE +: SPI_PINS]));
endmodule

// File: tb/sim_shared_port.sv
module sim_shared_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inputOnly = 1'b0;
  logic       wrData = 1'b0;
  logic       wrDir = 1'b0;
  logic [6:0] wrVal = '0;
  logic [6:0] rdData, rdDir, padOut, padOe;
  logic       sciEn = 1'b0;
  logic       spiEn = 1'b0;
  logic [5:0] periOut = '0;
  logic [5:0] periOe = '0;
  logic [6:0] padIn = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shared_port u0 (
    .clk(clk), .rstN(rstN), .inputOnly(inputOnly), .wrData(wrData),
    .wrDir(wrDir), .wrVal(wrVal), .rdData(rdData), .rdDir(rdDir),
    .sciEn(sciEn), .spiEn(spiEn), .periOut(periOut), .periOe(periOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic writeReg(input bit toDir, input logic [6:0] v);
    @(negedge clk);
    wrVal = v;
    if (toDir) wrDir = 1'b1; else wrData = 1'b1;
    @(negedge clk);
    wrDir = 1'b0;
    wrData = 1'b0;
  endtask

  task automatic doReset(input bit mode);
    @(negedge clk);
    rstN = 1'b0;
    inputOnly = mode;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [6:0] own, gOut, eOe, eOut, eRd, latchPat, padPat;
    // R1: reset state with engines requesting drive
    sciEn = 1'b1; spiEn = 1'b1; periOe = 6'h3F;
    repeat (2) @(negedge clk);
    check("R1 padOe in reset", padOe, 7'h00);
    rstN = 1'b1;
    sciEn = 1'b0; spiEn = 1'b0; periOe = '0;
    @(negedge clk);
    check("R1 rdDir after reset", rdDir, 7'h00);
    check("R1 padOe after reset", padOe, 7'h00);

    // R4: latch survives reset
    writeReg(1'b0, 7'h2A);
    writeReg(1'b1, 7'h7F);
    doReset(1'b0);
    check("R1 dir cleared", rdDir, 7'h00);
    writeReg(1'b1, 7'h7F);
    check("R4 latch kept through reset", padOut, 7'h2A);
    check("R5 read latch", rdData, 7'h2A);

    // Sweep: both variants, all engine enables, all direction patterns
    for (int m = 0; m < 2; m++) begin
      doReset(m[0]);
      for (int e = 0; e < 4; e++) begin
        for (int d = 0; d < 128; d++) begin
          latchPat = 7'((d * 37) ^ (e * 11));
          padPat   = 7'(~d) ^ (m[0] ? 7'h33 : 7'h4C) ^ 7'(e);
          writeReg(1'b0, latchPat);
          writeReg(1'b1, 7'(d));
          padIn   = padPat;
          sciEn   = e[0];
          spiEn   = e[1];
          periOut = 6'(d) ^ 6'h2A;
          periOe  = 6'(d + e);
          repeat (2) @(negedge clk);
          own  = (e[0] ? 7'h03 : 7'h00) | (e[1] ? 7'h3C : 7'h00);
          gOut = m[0] ? 7'h00 : 7'(d);
          eOe  = (own & {1'b0, periOe}) | (~own & gOut);
          eOut = (own & {1'b0, periOut}) | (~own & latchPat);
          eRd  = ((own | ~gOut) & padPat) | (~own & gOut & latchPat);
          check(m[0] ? "R3 padOe" : "R2 R7 R8 padOe", padOe, eOe);
          check(m[0] ? "R3 R10 padOut" : "R5 R7 R8 padOut", padOut, eOut);
          check("R6 R9 rdData", rdData, eRd);
          check(m[0] ? "R3 rdDir" : "R2 rdDir", rdDir, gOut);
          if (e == 3) begin
            check("R10 pin6 drive", {6'b0, padOe[6]}, {6'b0, gOut[6]});
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule